// File: doc/BRIEF.md
# Calibrated Timebase Divider

This block turns a 32.768 kHz oscillator enable stream into a one-second tick, a 512 Hz square wave for frequency measurement, and a strobe that marks the end of each minute. A signed digital trim corrects for crystal error. The block removes or adds counts at the divide-by-256 stage of the chain. It does this during one second per minute, in selected minutes of a repeating 64-minute cycle.

A 5-bit magnitude N and a sign bit set the trim. A register block upstream pulses the divider-clear input whenever the seconds or control register is written. An oscillator-off input freezes the chain. The calendar counters downstream consume the tick.

Top module: `tdiv_cal_timebase`

## Requirements
- R1: During and after a synchronous active-low reset, `tick_1hz`, `min_stb` and `sq_512` are all 0, and the minute cycle restarts at minute 0, second 0.
- R2: With N = 0, one `tick_1hz` pulse follows every 32768 advancing enables (256 × 128). An advancing enable is an `osc_en` pulse with `osc_off` low. The pulse appears in the clock after the enable that completes the second.
- R3: `min_stb` pulses together with every 60th tick, which is the tick that closes second 59 of each minute.
- R4: With `cal_pos` = 1, the first 256 enables of an adjusted second each count twice at the divide-by-256 stage. That second then lasts 32768 − 256 enables, and a full 64-minute cycle takes 512·N fewer enables than nominal.
- R5: With `cal_pos` = 0, the first 128 enables of an adjusted second are discarded. That second then lasts 32768 + 128 enables, and a full 64-minute cycle takes 256·N more enables than nominal.
- R6: The adjusted second is second 0 of minutes 0 to 2N−1 of the 64-minute cycle. With N = 31, minutes 0 to 61 are adjusted and minutes 62 and 63 are not.
- R7: `sq_512` is bit 5 of a free count of advancing enables. It toggles every 32 enables whatever the trim setting.
- R8: A `div_clr` pulse zeroes the sub-second count, the trim progress and the square-wave phase. The next tick then comes one full second of enables later. The second and minute positions are kept.
- R9: While `osc_off` = 1, no count advances: no tick occurs and `sq_512` holds its value.
- R10: `tick_1hz` and `min_stb` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_en | input | 1 | One-cycle pulse per oscillator period |
| osc_off | input | 1 | 1 freezes the whole divider |
| div_clr | input | 1 | Synchronous clear of the sub-second chain |
| cal_mag | input | 5 | Trim magnitude N, 0 to 31 |
| cal_pos | input | 1 | 1 inserts counts, 0 blanks counts |
| tick_1hz | output | 1 | One-cycle pulse per second |
| min_stb | output | 1 | One-cycle pulse at the end of each minute |
| sq_512 | output | 1 | Untrimmed 512 Hz square wave |

## Verification
The bench runs complete 64-minute cycles with N at 0, 1, 5 and 31 and both signs, and compares total enable counts. An error in the window length, quota or sign would move these totals by a whole multiple of the stage size. The first adjusted second is timed alone, which catches a window placed in the wrong second. N = 31 exposes an off-by-one at the 62-minute limit. Further tests clear the chain in mid-second, freeze it with the oscillator off, and check the square-wave rate during insertion; a design that shared the trimmed counter with the 512 Hz path would show extra toggles there.

// File: rtl/tdiv_pkg.sv
// Shared types and constants for the calibrated timebase divider.
// Assumes one minute cycle of 64 positions, held in a 6-bit counter.
package tdiv_pkg;
    localparam int MIN_W = 6;

    typedef enum logic [1:0] {
        TRIM_NONE  = 2'd0,
        TRIM_INS   = 2'd1,
        TRIM_BLANK = 2'd2
    } trim_mode_e;
endpackage

// File: rtl/tdiv_prescale.sv
// Divide-by-2^LO_W stage with trim. Inside an adjust window this stage
// steps by 2 (insert) or by 0 (blank) for a fixed number of enables.
// Assumes win_i and sec_wrap_i come from the seconds stage.
module tdiv_prescale
    import tdiv_pkg::*;
#(
    parameter int LO_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_en,
    input  logic osc_off,
    input  logic div_clr,
    input  logic win_i,
    input  logic sec_wrap_i,
    input  logic cal_pos,
    output logic carry_o
);
    localparam int LO_DIV = 1 << LO_W;
    localparam int INS_Q  = LO_DIV;
    localparam int BLK_Q  = LO_DIV / 2;
    localparam int ADJ_W  = LO_W + 1;

    logic [LO_W-1:0]  lo_cnt;
    logic [ADJ_W-1:0] adj_cnt;
    logic [LO_W:0]    step;
    logic [LO_W:0]    sum;
    logic             adv;
    trim_mode_e       mode;

    assign adv = osc_en & ~osc_off;

    // Choose the trim action for the current enable.
    always_comb begin
        mode = TRIM_NONE;
        if (win_i) begin
            if (cal_pos && adj_cnt < ADJ_W'(INS_Q))
                mode = TRIM_INS;
            else if (!cal_pos && adj_cnt < ADJ_W'(BLK_Q))
                mode = TRIM_BLANK;
        end
    end

    // Step size for the sub-256 counter and its carry.
    always_comb begin
        case (mode)
            TRIM_INS:   step = (LO_W+1)'(2);
            TRIM_BLANK: step = '0;
            default:    step = (LO_W+1)'(1);
        endcase
        sum     = {1'b0, lo_cnt} + step;
        carry_o = adv & ~div_clr & sum[LO_W];
    end

    // Advance the counter and track trim progress within the second.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt  <= '0;
            adj_cnt <= '0;
        end else if (div_clr) begin
            lo_cnt  <= '0;
            adj_cnt <= '0;
        end else if (adv) begin
            lo_cnt <= sum[LO_W-1:0];
            if (sec_wrap_i)
                adj_cnt <= '0;
            else if (mode != TRIM_NONE)
                adj_cnt <= adj_cnt + 1'b1;
        end
    end

    // R4: trim progress never exceeds the insertion quota.
    assert_adj_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        adj_cnt <= ADJ_W'(INS_Q));

    // R6: outside the window each enable moves the counter by exactly one.
    assert_plain_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !win_i && !div_clr) |=> (lo_cnt == $past(lo_cnt) + LO_W'(1)));

    // R9: with the oscillator off the counter holds.
    assert_off_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_off && !div_clr) |=> $stable(lo_cnt));
endmodule

// File: rtl/tdiv_seconds.sv
// Upper stage: counts prescaler carries into seconds, seconds into
// minutes, and minutes around a 64-position trim cycle. It raises the
// adjust window in second 0 of the first 2N minutes.
// Assumes carry_i is already gated by the divider clear.
module tdiv_seconds
    import tdiv_pkg::*;
#(
    parameter int HI_DIV      = 128,
    parameter int SEC_PER_MIN = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       carry_i,
    input  logic       div_clr,
    input  logic [4:0] cal_mag,
    output logic       win_o,
    output logic       sec_wrap_o,
    output logic       tick_o,
    output logic       min_o
);
    localparam int HI_W  = $clog2(HI_DIV);
    localparam int SEC_W = $clog2(SEC_PER_MIN);

    logic [HI_W-1:0]  hi_cnt;
    logic [SEC_W-1:0] sec_cnt;
    logic [MIN_W-1:0] min_cnt;
    logic             hi_last;
    logic             sec_last;

    assign hi_last    = (hi_cnt == HI_W'(HI_DIV - 1));
    assign sec_last   = (sec_cnt == SEC_W'(SEC_PER_MIN - 1));
    assign sec_wrap_o = carry_i & hi_last;
    assign win_o      = (sec_cnt == '0) && (min_cnt < {cal_mag, 1'b0});

    // Count prescaler carries into whole seconds.
    always_ff @(posedge clk) begin
        if (!rst_n || div_clr)
            hi_cnt <= '0;
        else if (carry_i)
            hi_cnt <= hi_last ? '0 : hi_cnt + 1'b1;
    end

    // Track second within minute and minute within the trim cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_cnt <= '0;
            min_cnt <= '0;
        end else if (sec_wrap_o) begin
            if (sec_last) begin
                sec_cnt <= '0;
                min_cnt <= min_cnt + 1'b1;
            end else begin
                sec_cnt <= sec_cnt + 1'b1;
            end
        end
    end

    // Register the tick and minute strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_o <= 1'b0;
            min_o  <= 1'b0;
        end else begin
            tick_o <= sec_wrap_o;
            min_o  <= sec_wrap_o & sec_last;
        end
    end

    // R3: the minute strobe only comes with a tick.
    assert_min_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        min_o |-> tick_o);

    // R10: the tick is a single-cycle pulse.
    assert_tick_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/tdiv_testsq.sv
// Untrimmed square-wave divider for frequency test. It counts every
// advancing enable, whatever the trim state.
// Assumes the enable rate is 2^SQ_W times the wanted output rate.
module tdiv_testsq #(
    parameter int SQ_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_en,
    input  logic osc_off,
    input  logic div_clr,
    output logic sq_o
);
    logic [SQ_W-1:0] sq_cnt;
    logic            adv;

    assign adv  = osc_en & ~osc_off;
    assign sq_o = sq_cnt[SQ_W-1];

    // Free-running count of oscillator enables.
    always_ff @(posedge clk) begin
        if (!rst_n || div_clr)
            sq_cnt <= '0;
        else if (adv)
            sq_cnt <= sq_cnt + 1'b1;
    end

    // R9: the output holds while no enable advances.
    assert_sq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !div_clr) |=> $stable(sq_o));
endmodule

// File: rtl/tdiv_cal_timebase.sv
// Top of the calibrated timebase divider. It joins the trimmed prescaler,
// the seconds/minute stage and the untrimmed test square wave.
// Assumes osc_en is a one-cycle pulse per oscillator period.
module tdiv_cal_timebase #(
    parameter int LO_W        = 8,
    parameter int HI_DIV      = 128,
    parameter int SEC_PER_MIN = 60,
    parameter int SQ_W        = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_en,
    input  logic       osc_off,
    input  logic       div_clr,
    input  logic [4:0] cal_mag,
    input  logic       cal_pos,
    output logic       tick_1hz,
    output logic       min_stb,
    output logic       sq_512
);
    logic carry;
    logic win;
    logic sec_wrap;

    tdiv_prescale #(.LO_W(LO_W)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_en     (osc_en),
        .osc_off    (osc_off),
        .div_clr    (div_clr),
        .win_i      (win),
        .sec_wrap_i (sec_wrap),
        .cal_pos    (cal_pos),
        .carry_o    (carry)
    );

    tdiv_seconds #(.HI_DIV(HI_DIV), .SEC_PER_MIN(SEC_PER_MIN)) u_sec (
        .clk        (clk),
        .rst_n      (rst_n),
        .carry_i    (carry),
        .div_clr    (div_clr),
        .cal_mag    (cal_mag),
        .win_o      (win),
        .sec_wrap_o (sec_wrap),
        .tick_o     (tick_1hz),
        .min_o      (min_stb)
    );

    tdiv_testsq #(.SQ_W(SQ_W)) u_sq (
        .clk     (clk),
        .rst_n   (rst_n),
        .osc_en  (osc_en),
        .osc_off (osc_off),
        .div_clr (div_clr),
        .sq_o    (sq_512)
    );
endmodule

// File: tb/tb_tdiv_cal_timebase.sv
module tb_tdiv_cal_timebase;
    localparam int LO_W = 3;
    localparam int HI_DIV = 4;
    localparam int SPM = 3;
    localparam int SQ_W = 4;
    localparam int LO = 1 << LO_W;
    localparam int SEC = LO * HI_DIV;
    localparam int SQP = 1 << SQ_W;

    logic clk = 0;
    logic rst_n = 0;
    logic osc_en = 0, osc_off = 0, div_clr = 0, cal_pos = 0;
    logic [4:0] cal_mag = 0;
    logic tick_1hz, min_stb, sq_512;

    int total = 0, bad = 0;
    int n_tick = 0, n_str = 0, n_sqr = 0;
    int cyc = 0;
    bit cmp_en = 0, done = 0;

    // behavioural reference state
    int m_sub = 0, m_adj = 0, m_s = 0, m_m = 0, m_cnt = 0;
    bit e_tick = 0, e_str = 0;
    bit prev_tick = 0, prev_sq = 0;

    tdiv_cal_timebase #(.LO_W(LO_W), .HI_DIV(HI_DIV), .SEC_PER_MIN(SPM), .SQ_W(SQ_W)) dut (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .osc_off(osc_off), .div_clr(div_clr),
        .cal_mag(cal_mag), .cal_pos(cal_pos), .tick_1hz(tick_1hz), .min_stb(min_stb), .sq_512(sq_512)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference model, updated on the same edge as the design
    always @(posedge clk) begin
        int step;
        bit win;
        e_tick = 0; e_str = 0;
        if (!rst_n) begin
            m_sub = 0; m_adj = 0; m_s = 0; m_m = 0; m_cnt = 0;
        end else if (div_clr) begin
            m_sub = 0; m_adj = 0; m_cnt = 0;
        end else if (osc_en && !osc_off) begin
            m_cnt = (m_cnt + 1) % SQP;
            win = (m_s == 0) && (m_m < 2 * cal_mag);
            step = 1;
            if (win) begin
                if (cal_pos && m_adj < LO) begin step = 2; m_adj++; end
                else if (!cal_pos && m_adj < LO / 2) begin step = 0; m_adj++; end
            end
            m_sub += step;
            if (m_sub >= SEC) begin
                m_sub -= SEC; m_adj = 0; e_tick = 1;
                if (m_s == SPM - 1) begin m_s = 0; e_str = 1; m_m = (m_m + 1) % 64; end
                else m_s++;
            end
        end
    end

    // per-clock comparison and event counting
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            chk(tick_1hz === e_tick, "R2 tick vs model", tick_1hz, e_tick);
            chk(min_stb === e_str, "R3 strobe vs model", min_stb, e_str);
            chk(sq_512 === (m_cnt >= SQP / 2), "R7 sq vs model", sq_512, m_cnt >= SQP / 2);
            if (prev_tick) chk(!tick_1hz, "R10 tick width", tick_1hz, 0);
            if (tick_1hz) n_tick++;
            if (min_stb) n_str++;
            if (sq_512 && !prev_sq) n_sqr++;
            prev_tick = tick_1hz;
            prev_sq = sq_512;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; osc_en = 0; div_clr = 0; osc_off = 0;
        repeat (3) @(negedge clk);
        chk(tick_1hz == 0 && min_stb == 0 && sq_512 == 0, "R1 reset outputs",
            {tick_1hz, min_stb, sq_512}, 0);
        rst_n = 1;
        #1;
        n_tick = 0; n_str = 0; n_sqr = 0; prev_tick = 0; prev_sq = 0;
        cmp_en = 1;
    endtask

    task automatic en_pulse();
        @(negedge clk);
        osc_en = 1;
        @(negedge clk);
        osc_en = 0;
        #1;
    endtask

    task automatic run_to(input int target, output int used);
        used = 0;
        while (n_tick < target) begin
            en_pulse();
            used++;
        end
    endtask

    task automatic full_cycle(input int mag, input bit pos, input string tag);
        int used, exp;
        cal_mag = 5'(mag); cal_pos = pos;
        do_reset();
        run_to(64 * SPM, used);
        exp = 64 * SPM * SEC + (pos ? -2 * mag * LO : mag * LO);
        chk(used == exp, tag, used, exp);
        chk(n_str == 64, "R3 strobes per cycle", n_str, 64);
    endtask

    initial begin
        int used, sq_before, t0;
        // R2: nominal cycle
        full_cycle(0, 0, "R2 nominal cycle total");
        // R4: first adjusted second is shortened, then whole cycle
        cal_mag = 1; cal_pos = 1;
        do_reset();
        run_to(1, used);
        chk(used == SEC - LO, "R4 inserted second length", used, SEC - LO);
        run_to(64 * SPM, t0);
        chk(used + t0 == 64 * SPM * SEC - 2 * LO, "R4 N=1 cycle total", used + t0, 64 * SPM * SEC - 2 * LO);
        full_cycle(5, 1, "R4 N=5 positive cycle total");
        // R5 and R6: negative, widest window
        cal_mag = 31; cal_pos = 0;
        do_reset();
        run_to(1, used);
        chk(used == SEC + LO / 2, "R5 blanked second length", used, SEC + LO / 2);
        full_cycle(31, 0, "R5 R6 N=31 negative cycle total");
        full_cycle(31, 1, "R6 N=31 positive cycle total");
        // R7: square wave rate during insertion
        cal_mag = 31; cal_pos = 1;
        do_reset();
        repeat (4 * SQP) en_pulse();
        chk(n_sqr == 4, "R7 sq rising edges under trim", n_sqr, 4);
        // R8: mid-second clear
        cal_mag = 0; cal_pos = 0;
        do_reset();
        repeat (10) en_pulse();
        @(negedge clk); div_clr = 1;
        @(negedge clk); div_clr = 0; #1;
        chk(sq_512 == 0, "R8 sq phase cleared", sq_512, 0);
        run_to(1, used);
        chk(used == SEC, "R8 full second after clear", used, SEC);
        // R9: oscillator off
        osc_off = 1;
        sq_before = sq_512;
        t0 = n_tick;
        repeat (3 * SEC) en_pulse();
        chk(n_tick == t0, "R9 no tick while off", n_tick, t0);
        chk(sq_512 == sq_before, "R9 sq holds while off", sq_512, sq_before);
        osc_off = 0;
        run_to(t0 + 1, used);
        chk(used == SEC, "R9 resumes with full second", used, SEC);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule